// File: doc/BRIEF.md
# External Bus Write Sequencer

This block turns host write requests into write cycles on an asynchronous external memory bus. A request carries an address, a data word and a zone index. The block accepts it through a valid/ready handshake and then runs three phases, each a programmable number of timing-clock periods:

- **Setup:** the selected chip-select and the direction line go low.
- **Strobe:** write-enable is low and the data is driven.
- **Hold:** write-enable is released, but the data, chip-select and direction are kept.

A one-cycle completion pulse marks the end of the hold phase. The strobe phase can be stretched by a ready pin from the external device. The pin is asynchronous, so it passes through two flops before the block uses it.

The block also produces a bus clock, which is either the timing clock itself or the timing clock divided by two. Every access starts on a rising edge of that bus clock. When a request arrives in the wrong half of a divided clock, the block inserts one idle alignment cycle first. Between accesses the address bus holds the last address with its lowest bit forced high. In 16-bit data mode, the second write-enable pin carries that address bit.

Top module: `ext_wr_sequencer`

## Requirements
- R1: After reset, all of the following hold:
  - every chip-select, both write-enables and the direction line are high;
  - the data enable and the completion pulse are low;
  - `req_ready` is high;
  - the address bus reads 1, which is address 0 with bit 0 forced high.
- R2: The handshake behaves as follows:
  - `req_ready` is high only while no access is in progress, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high.
  - `done` is high for exactly one cycle, the cycle after the last hold cycle, and `req_ready` is high in that same cycle.
- R3: An access runs in this order:
  - The setup phase lasts `cfg_lead` cycles. `bus_cs_n[zone]` and `bus_rnw` go low in its first cycle.
  - `bus_we0_n` is low exactly during the strobe phase.
  - The hold phase lasts `cfg_trail` cycles, after which chip-select and direction return high.
  - A zone index of `ZONES` or more selects no chip-select.
- R4: `bus_doe` is high from the first strobe cycle through the last hold cycle. While it is high, `bus_dout` carries the request data in 32-bit mode, and only the lower 16 bits zero-extended in 16-bit mode.
- R5: The address bus shows the request address from setup through hold. At all other times it shows the last address driven, with bit 0 forced to 1; before any access that is 0 with bit 0 set.
- R6: In 32-bit mode (`cfg_bus32`=1), `bus_we1_n` equals `bus_we0_n`. In 16-bit mode it equals `bus_addr[0]`.
- R7: With `cfg_half_clk`=0, `bus_clk` is the timing clock. With `cfg_half_clk`=1, `bus_clk` is a divider that:
  - starts low after reset and toggles every timing cycle;
  - is high during the first setup cycle of every access.
  A request taken while the divider is high is preceded by one alignment cycle. In that cycle all strobes stay inactive and the address is held.
- R8: With `cfg_use_rdy`=1, the strobe phase ends only at a strobe-end edge where the synchronized ready level is high. Otherwise it is extended one cycle and tested again.
  - Counting edges from the start of setup, the pin value at edge (lead + active − 2) decides the first test.
  - The pin value at edge (lead + active − 3 + n) decides test n.
- R9: With `cfg_use_rdy`=0, the strobe phase lasts exactly `cfg_active` cycles whatever the ready pin does.
- R10: A phase count of 0 is treated as 1.
- R11: The setting lead 1, active 3, trail 1 with ready used and the full-rate bus clock gives three write-enable cycles when ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lead | input | CW | Setup phase length in cycles |
| cfg_active | input | CW | Strobe phase length in cycles |
| cfg_trail | input | CW | Hold phase length in cycles |
| cfg_use_rdy | input | 1 | Stretch the strobe phase with the ready pin |
| cfg_half_clk | input | 1 | Bus clock is the timing clock divided by two |
| cfg_bus32 | input | 1 | 1: 32-bit data bus, 0: 16-bit data bus |
| req_valid | input | 1 | Host write request valid |
| req_ready | output | 1 | Sequencer idle, can take a request |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_zone | input | ZW | Chip-select index |
| done | output | 1 | One-cycle pulse after the hold phase |
| bus_clk | output | 1 | External bus clock |
| bus_cs_n | output | ZONES | Active-low chip-selects |
| bus_rnw | output | 1 | Direction, low while writing |
| bus_we0_n | output | 1 | Active-low write-enable, lower lane |
| bus_we1_n | output | 1 | Upper-lane write-enable, or address bit 0 in 16-bit mode |
| bus_addr | output | AW | External address bus |
| bus_dout | output | DW | Data to drive on the bus |
| bus_doe | output | 1 | Data output enable |
| bus_rdy_async | input | 1 | Asynchronous ready from the device |

## Verification
Writes are issued under several ready patterns, and each pattern separates a different fault:

| Ready pattern | Configuration | What it tells apart |
|---|---|---|
| Held high | Example setting | A wrong phase length or strobe placement |
| Pseudo-random | Ready used | Sampling the pin at the wrong edge or with the wrong synchronizer depth |
| Held low | Ready ignored | A design that leaks ready into the phase length |

Further runs cover these cases:
- Zero phase counts.
- 16-bit mode with odd and even addresses, which exposes the pin sharing and address bit 0.
- The divided clock, with request gaps that alternate between the aligned and misaligned divider phases, which shows whether the alignment cycle is present.

// File: rtl/ext_wr_sequencer.sv
module ext_wr_sequencer #(
  parameter int AW    = 20,
  parameter int DW    = 32,
  parameter int CW    = 4,
  parameter int ZONES = 3,
  parameter int ZW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_lead,
  input  logic [CW-1:0] cfg_active,
  input  logic [CW-1:0] cfg_trail,
  input  logic          cfg_use_rdy,
  input  logic          cfg_half_clk,
  input  logic          cfg_bus32,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [ZW-1:0] req_zone,
  output logic          done,
  output logic          bus_clk,
  output logic [ZONES-1:0] bus_cs_n,
  output logic          bus_rnw,
  output logic          bus_we0_n,
  output logic          bus_we1_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic          bus_rdy_async
);
  localparam int HW = DW / 2;
  localparam logic [CW-1:0] ONE = CW'(1);

  typedef enum logic [2:0] {S_IDLE, S_ALIGN, S_LEAD, S_ACT, S_TRAIL} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          div_q, rdy_m, rdy_s, done_q;
  logic [AW-1:0] pend_addr, addr_q;
  logic [DW-1:0] data_q;
  logic [ZW-1:0] zone_q;

  function automatic logic [CW-1:0] at_least_one(input logic [CW-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  wire aligned = !cfg_half_clk || !div_q;
  wire last    = (cnt == ONE);
  wire busy    = (st == S_LEAD) || (st == S_ACT) || (st == S_TRAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      div_q     <= 1'b0;
      rdy_m     <= 1'b0;
      rdy_s     <= 1'b0;
      done_q    <= 1'b0;
      pend_addr <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      zone_q    <= '0;
    end else begin
      div_q  <= !div_q;
      rdy_m  <= bus_rdy_async;
      rdy_s  <= rdy_m;
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          pend_addr <= req_addr;
          data_q    <= req_data;
          zone_q    <= req_zone;
          if (aligned) begin
            st     <= S_LEAD;
            addr_q <= req_addr;
            cnt    <= at_least_one(cfg_lead);
          end else begin
            st <= S_ALIGN;
          end
        end
        S_ALIGN: begin
          st     <= S_LEAD;
          addr_q <= pend_addr;
          cnt    <= at_least_one(cfg_lead);
        end
        S_LEAD: if (last) begin
          st  <= S_ACT;
          cnt <= at_least_one(cfg_active);
        end else begin
          cnt <= cnt - ONE;
        end
        S_ACT: if (!last) begin
          cnt <= cnt - ONE;
        end else if (!cfg_use_rdy || rdy_s) begin
          st  <= S_TRAIL;
          cnt <= at_least_one(cfg_trail);
        end
        S_TRAIL: if (last) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end else begin
          cnt <= cnt - ONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < ZONES; i++) begin : g_cs
    assign bus_cs_n[i] = !(busy && zone_q == ZW'(i));
  end

  assign req_ready = (st == S_IDLE);
  assign done      = done_q;
  assign bus_clk   = cfg_half_clk ? div_q : clk;
  assign bus_rnw   = !busy;
  assign bus_we0_n = (st != S_ACT);
  assign bus_addr  = busy ? addr_q : {addr_q[AW-1:1], 1'b1};
  assign bus_we1_n = cfg_bus32 ? bus_we0_n : bus_addr[0];
  assign bus_doe   = (st == S_ACT) || (st == S_TRAIL);
  assign bus_dout  = cfg_bus32 ? data_q : {{(DW-HW){1'b0}}, data_q[HW-1:0]};
endmodule

// File: rtl/ext_wr_sequencer_chk.sv
module ext_wr_sequencer_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_half_clk,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic          bus_clk,
  input logic          bus_rnw,
  input logic          bus_we0_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_doe
);
  // R3
  we_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we0_n |-> !bus_rnw);

  // R3
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rnw && $past(!bus_rnw) |-> $stable(bus_addr));

  // R4
  doe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> !bus_rnw);

  // R5
  idle_a0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rnw |-> bus_addr[0]);

  // R7
  lead_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_half_clk && $fell(bus_rnw) |-> bus_clk);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
endmodule

bind ext_wr_sequencer ext_wr_sequencer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_half_clk(cfg_half_clk),
  .req_valid(req_valid), .req_ready(req_ready), .done(done),
  .bus_clk(bus_clk), .bus_rnw(bus_rnw), .bus_we0_n(bus_we0_n),
  .bus_addr(bus_addr), .bus_doe(bus_doe)
);

// File: tb/ext_wr_sequencer_bench.sv
module ext_wr_sequencer_bench;
  localparam int AW = 20, DW = 32, CW = 4, ZONES = 3, ZW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] cfg_lead = 1, cfg_active = 3, cfg_trail = 1;
  logic cfg_use_rdy = 1'b1, cfg_half_clk = 1'b0, cfg_bus32 = 1'b1;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [ZW-1:0] req_zone = '0;
  logic bus_rdy = 1'b1;
  logic req_ready, done, bus_clk, bus_rnw, bus_we0_n, bus_we1_n, bus_doe;
  logic [ZONES-1:0] bus_cs_n;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout;

  ext_wr_sequencer u_ext_wr_sequencer (
    .clk(clk), .rst_n(rst_n), .cfg_lead(cfg_lead), .cfg_active(cfg_active),
    .cfg_trail(cfg_trail), .cfg_use_rdy(cfg_use_rdy), .cfg_half_clk(cfg_half_clk),
    .cfg_bus32(cfg_bus32), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_zone(req_zone), .done(done),
    .bus_clk(bus_clk), .bus_cs_n(bus_cs_n), .bus_rnw(bus_rnw),
    .bus_we0_n(bus_we0_n), .bus_we1_n(bus_we1_n), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_rdy_async(bus_rdy)
  );

  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int atl1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // ready pin patterns: 0 high, 1 pseudo-random, 2 low
  int rdy_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    bus_rdy = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 2) ? 1'b0 : lfsr[0];
  end

  // behavioural reference: 0 idle, 1 align, 2 setup, 3 strobe, 4 hold
  int mph, t, ext, L, A, T, edge_no;
  bit mdiv, m_done;
  bit hist[$];
  logic [AW-1:0] m_addr, p_addr;
  logic [DW-1:0] m_data;
  int m_zone;

  task automatic start_access();
    mph = 2; t = 0; ext = 0;
    L = atl1(int'(cfg_lead)); A = atl1(int'(cfg_active)); T = atl1(int'(cfg_trail));
    m_addr = p_addr;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mph = 0; mdiv = 0; m_done = 0; edge_no = 0; hist.delete();
      m_addr = '0; p_addr = '0; m_data = '0; m_zone = 0;
    end else begin
      hist.push_back(bus_rdy);
      m_done = 0;
      case (mph)
        0: if (req_valid) begin
          p_addr = req_addr; m_data = req_data; m_zone = int'(req_zone);
          if (!cfg_half_clk || !mdiv) start_access(); else mph = 1;
        end
        1: start_access();
        default: begin
          t++;
          if (mph == 3 && t == L + A + ext && cfg_use_rdy && !hist[edge_no - 2]) ext++;
          if (t < L) mph = 2;
          else if (t < L + A + ext) mph = 3;
          else if (t < L + A + ext + T) mph = 4;
          else begin mph = 0; m_done = 1; end
        end
      endcase
      mdiv = !mdiv;
      edge_no++;
    end
  end

  always @(posedge clk) begin
    #5;
    if (rst_n && !finished) begin
      bit busy;
      logic [AW-1:0] ea;
      logic [ZONES-1:0] ecs;
      logic ewe;
      busy = (mph >= 2);
      ea = busy ? m_addr : {m_addr[AW-1:1], 1'b1};
      ewe = !(mph == 3);
      for (int i = 0; i < ZONES; i++) ecs[i] = !(busy && m_zone == i);
      chk("R3 cs_n", 64'(bus_cs_n), 64'(ecs));
      chk("R3 rnw", 64'(bus_rnw), 64'(!busy));
      chk("R3/R8/R9 we0_n", 64'(bus_we0_n), 64'(ewe));
      chk("R5 addr", 64'(bus_addr), 64'(ea));
      chk("R6 we1_n", 64'(bus_we1_n), 64'(cfg_bus32 ? ewe : ea[0]));
      chk("R4 doe", 64'(bus_doe), 64'(mph == 3 || mph == 4));
      if (mph == 3 || mph == 4)
        chk("R4 dout", 64'(bus_dout), 64'(cfg_bus32 ? m_data : {16'h0, m_data[15:0]}));
      chk("R2 done", 64'(done), 64'(m_done));
      chk("R2 req_ready", 64'(req_ready), 64'(mph == 0));
      chk("R7 bus_clk", 64'(bus_clk), 64'(cfg_half_clk ? mdiv : 1'b1));
    end
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int z, output int we_cycles);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d; req_zone = ZW'(z);
    @(negedge clk);
    req_valid = 1'b0;
    we_cycles = 0;
    while (!done) begin
      if (!bus_we0_n) we_cycles++;
      @(negedge clk);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog act=%0d exp=<100000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int w;
    #35;
    // R1 reset state
    chk("R1 cs_n", 64'(bus_cs_n), 64'({ZONES{1'b1}}));
    chk("R1 rnw/we", 64'({bus_rnw, bus_we0_n, bus_we1_n}), 64'(3'b111));
    chk("R1 doe/done", 64'({bus_doe, done}), 64'(0));
    chk("R1 req_ready", 64'(req_ready), 64'(1));
    chk("R1 addr", 64'(bus_addr), 64'(1));
    @(negedge clk); rst_n = 1'b1;

    // R11 example setting, ready high
    for (int k = 0; k < 3; k++) begin
      do_write(AW'(20'h1_2340 + k), 32'hCAFE_0000 + k, k, w);
      chk("R11 strobe cycles", 64'(w), 64'(3));
    end

    // R8 pseudo-random ready, several lengths
    rdy_mode = 1;
    for (int k = 0; k < 12; k++) begin
      cfg_lead = CW'(1 + k % 3); cfg_active = CW'(1 + k % 4); cfg_trail = CW'(1 + k % 2);
      do_write(AW'(k * 37 + 6), 32'h1234_5678 ^ k, k % 3, w);
      chk("R8 strobe at least active", 64'(w >= 1 + k % 4), 64'(1));
    end

    // R9 ready ignored while held low
    rdy_mode = 2; cfg_use_rdy = 1'b0;
    cfg_lead = 2; cfg_active = 4; cfg_trail = 3;
    do_write(20'hABCDE, 32'h5555_AAAA, 2, w);
    chk("R9 strobe cycles", 64'(w), 64'(4));

    // R10 zero counts
    cfg_lead = 0; cfg_active = 0; cfg_trail = 0;
    do_write(20'h00F0F, 32'h0BAD_F00D, 1, w);
    chk("R10 strobe cycles", 64'(w), 64'(1));

    // R6 R4 16-bit mode, odd and even addresses, out-of-range zone
    cfg_bus32 = 1'b0; cfg_lead = 1; cfg_active = 2; cfg_trail = 2;
    do_write(20'h00101, 32'hDEAD_BEEF, 0, w);
    do_write(20'h00200, 32'h8765_4321, 3, w);
    chk("R6 idle we1_n", 64'(bus_we1_n), 64'(1));

    // R7 divided clock, gaps alternate the alignment phase
    cfg_bus32 = 1'b1; cfg_half_clk = 1'b1; cfg_use_rdy = 1'b1; rdy_mode = 1;
    for (int k = 0; k < 8; k++) begin
      cfg_lead = CW'(1 + k % 2); cfg_active = CW'(2 + k % 3); cfg_trail = CW'(1 + k % 3);
      for (int g = 0; g < k % 2; g++) @(negedge clk);
      do_write(AW'(20'h40000 + k * 3), 32'hF0F0_0000 | k, k % 3, w);
    end
    cfg_half_clk = 1'b0; rdy_mode = 0;
    do_write(20'h7FFFE, 32'h0000_0001, 0, w);
    chk("R11 strobe cycles again", 64'(w), 64'(2 + 7 % 3));

    repeat (4) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule